// File: doc/BRIEF.md
# SPI Master with Per-Select Timing

This block is a serial peripheral interface master that serves up to four peripherals on separate active-low select lines. A host hands it one byte and a target select index per request over a valid/ready handshake. The block asserts the chosen select line and waits out a setup delay. It then clocks eight bits out and in, waits out a hold delay and releases the line. The byte received from the peripheral comes back together with a one-cycle pulse.

Each select line has its own timing inputs: a clock divisor, a setup delay and a hold delay. When the target changes, the serial clock rate and the delays change with it, and nothing has to be reprogrammed. One shared gap value sets the least number of idle cycles between releasing one select line and asserting a different one. Frames are eight bits, most significant bit first, in clock mode 0. The target comes from the request's index input and is never taken from the data.

The controller has five states. `ST_IDLE` waits for a request. `ST_GAP` waits out the rest of the shared select gap. `ST_SETUP` holds the select low before the first clock edge. `ST_SHIFT` runs the eight clock periods. `ST_HOLD` waits between transfers with the select still low.

The transitions are as follows:
- `IDLE→SETUP`: a request is accepted and no gap is pending.
- `IDLE→GAP`: a request for a different select is accepted while the gap is still running.
- `IDLE→IDLE`: a request with a zero divisor is refused.
- `GAP→SETUP`: the gap has expired.
- `SETUP→SHIFT`: the setup delay has ended.
- `SHIFT→HOLD`: the last falling clock edge.
- `HOLD→SHIFT`: a request for the same select is waiting when the hold delay ends.
- `HOLD→GAP`: a request for a different select is waiting.
- `HOLD→IDLE`: no request is waiting, or the waiting request is refused.

Top module: `spi_sel_master`

## Requirements
- R1: During reset and just after it, `cs_n` is 4'b1111, `sclk` is 0, `req_ready` is 1, and `rsp_valid` and `cfg_err` are 0.
- R2: At most one `cs_n` bit is ever low. Bit i is the select for index i. Only the requested line goes low, and all lines are high between transfers.
- R3: For a target with divisor D (1..255) on `cfg_div[i]`, every low half and every high half of `sclk` during a frame lasts exactly D clock cycles.
- R4: A request whose target has a divisor of 0 is consumed. `cfg_err` pulses high for one cycle and no select line goes low.
- R5: The first rising `sclk` edge of a transfer comes exactly P+1+D cycles after the select goes low. P is `cfg_pre[i]`.
- R6: When no request for the same select is waiting, the select goes high exactly H+1 cycles after the last falling `sclk` edge. H is `cfg_post[i]`.
- R7: When a request for the same select is waiting at the end of the hold delay, the select stays low. The next frame's first rising edge comes exactly H+1+D cycles after the previous frame's last falling edge.
- R8: A select line goes low at least G+1 cycles after a different line was released, where G is `cfg_gap`. When the request is already waiting at the release, the wait is exactly G+1 cycles.
- R9: `sclk` idles low. `mosi` carries the byte most significant bit first and changes only while `sclk` is low. `miso` is sampled at the clock edge that raises `sclk`.
- R10: `rsp_valid` is high for exactly one cycle, starting at the edge of the eighth `sclk` rise. While it is high, `rsp_data` holds the eight bits sampled from `miso`, first bit in the MSB.
- R11: `req_ready` is high only in the idle state and in the last cycle of the hold delay, so it is low whenever `sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 4x8 | Serial clock divisor for each select; 0 is illegal |
| cfg_pre | input | 4x8 | Setup delay for each select, between select assert and clocking |
| cfg_post | input | 4x8 | Hold delay for each select, after the last clock edge |
| cfg_gap | input | 8 | Shared idle gap before a different select is asserted |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_cs | input | 2 | Target select index |
| req_data | input | 8 | Byte to send |
| rsp_valid | output | 1 | One-cycle pulse when a received byte is ready |
| rsp_data | output | 8 | Received byte |
| cfg_err | output | 1 | One-cycle pulse when a request was refused for a zero divisor |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low select lines |

## Verification
A table of six frames runs through every select line, so that the per-line divisor, setup and hold values are all distinct. Each frame uses a different outgoing byte and a different peripheral byte, so swapped lines, reversed bit order or an off-by-one delay count each give a mismatch. Directed runs then compare these cases:
- two queued frames to the same line against two to different lines, which separates R7 from R8;
- a divisor of 0, which tests the refusal;
- a divisor of 255, which tests the widest half period.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD
    } spi_state_e;

endpackage

// File: rtl/spi_dly_cnt.sv
module spi_dly_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int DW   = 8,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DW-1:0]   tx_in,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    input  logic            miso,
    output logic            sclk,
    output logic            mosi,
    output logic [DW-1:0]   rx_byte,
    output logic            done,
    output logic            last_fall
);

    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    logic [DW-1:0]   tx_q;
    logic [DW-1:0]   rx_q;
    logic [DIVW-1:0] pcnt_q;
    logic [BW-1:0]   bitn_q;
    logic            sclk_q;
    logic            done_q;
    logic            half_end;

    assign half_end  = run && (pcnt_q == '0);
    assign last_fall = half_end && sclk_q && (bitn_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            rx_q   <= '0;
            pcnt_q <= '0;
            bitn_q <= '0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                tx_q   <= tx_in;
                pcnt_q <= div - DIVW'(1);
                bitn_q <= BW'(DW - 1);
                sclk_q <= 1'b0;
            end else if (run) begin
                if (pcnt_q != '0) begin
                    pcnt_q <= pcnt_q - DIVW'(1);
                end else if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[DW-2:0], miso};
                    pcnt_q <= div - DIVW'(1);
                    done_q <= (bitn_q == '0);
                end else begin
                    sclk_q <= 1'b0;
                    if (bitn_q != '0) begin
                        tx_q   <= {tx_q[DW-2:0], 1'b0};
                        bitn_q <= bitn_q - BW'(1);
                        pcnt_q <= div - DIVW'(1);
                    end
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = tx_q[DW-1];
    assign rx_byte = rx_q;
    assign done    = done_q;

    AST_HALF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && pcnt_q != '0) |=> (sclk_q == $past(sclk_q))); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R10

    AST_MOSI_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && $past(sclk_q)) |-> $stable(tx_q)); // R9

endmodule

// File: rtl/spi_sel_master.sv
module spi_sel_master
    import spi_sel_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DW     = 8,
    parameter int DIVW   = 8,
    parameter int DLYW   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CS-1:0][DIVW-1:0] cfg_div,
    input  logic [NUM_CS-1:0][DLYW-1:0] cfg_pre,
    input  logic [NUM_CS-1:0][DLYW-1:0] cfg_post,
    input  logic [DLYW-1:0]             cfg_gap,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [$clog2(NUM_CS)-1:0]  req_cs,
    input  logic [DW-1:0]              req_data,
    output logic                       rsp_valid,
    output logic [DW-1:0]              rsp_data,
    output logic                       cfg_err,
    output logic                       sclk,
    output logic                       mosi,
    input  logic                       miso,
    output logic [NUM_CS-1:0]          cs_n
);

    localparam int CSW  = $clog2(NUM_CS);
    localparam int GAPW = DLYW + 1;

    spi_state_e state_q, state_d;

    logic [CSW-1:0]    cur_cs_q, last_cs_q, sel_cs;
    logic              have_last_q;
    logic [NUM_CS-1:0] cs_n_q;
    logic              err_q;

    logic              cap_cs, cs_set, cs_clr, err_set;
    logic              dly_load, gap_load, sh_load, sh_run;
    logic [DLYW-1:0]   dly_val;
    logic [DLYW-1:0]   dly_cnt;
    logic [GAPW-1:0]   gap_cnt;
    logic              dly_zero, gap_ok;
    logic              sh_last_fall, sh_done;
    logic [DW-1:0]     sh_rx;

    assign dly_zero = (dly_cnt == '0);
    assign gap_ok   = (gap_cnt <= GAPW'(1));
    assign sel_cs   = cap_cs ? req_cs : cur_cs_q;
    assign req_ready = (state_q == ST_IDLE) || ((state_q == ST_HOLD) && dly_zero);

    spi_dly_cnt #(.W(DLYW)) u_phase_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dly_load),
        .val   (dly_val),
        .cnt   (dly_cnt)
    );

    spi_dly_cnt #(.W(GAPW)) u_gap_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gap_load),
        .val   ({1'b0, cfg_gap} + GAPW'(1)),
        .cnt   (gap_cnt)
    );

    spi_shift_core #(.DW(DW), .DIVW(DIVW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .tx_in     (req_data),
        .run       (sh_run),
        .div       (cfg_div[sel_cs]),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .rx_byte   (sh_rx),
        .done      (sh_done),
        .last_fall (sh_last_fall)
    );

    // Next-state and control strobes
    always_comb begin
        state_d  = state_q;
        cap_cs   = 1'b0;
        cs_set   = 1'b0;
        cs_clr   = 1'b0;
        err_set  = 1'b0;
        dly_load = 1'b0;
        dly_val  = '0;
        gap_load = 1'b0;
        sh_load  = 1'b0;
        sh_run   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (cfg_div[req_cs] == '0) begin
                        err_set = 1'b1;
                    end else begin
                        cap_cs  = 1'b1;
                        sh_load = 1'b1;
                        if (have_last_q && (req_cs != last_cs_q) && !gap_ok) begin
                            state_d = ST_GAP;
                        end else begin
                            state_d  = ST_SETUP;
                            cs_set   = 1'b1;
                            dly_load = 1'b1;
                            dly_val  = cfg_pre[req_cs];
                        end
                    end
                end
            end
            ST_GAP: begin
                if (gap_ok) begin
                    state_d  = ST_SETUP;
                    cs_set   = 1'b1;
                    dly_load = 1'b1;
                    dly_val  = cfg_pre[cur_cs_q];
                end
            end
            ST_SETUP: begin
                if (dly_zero) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                sh_run = 1'b1;
                if (sh_last_fall) begin
                    state_d  = ST_HOLD;
                    dly_load = 1'b1;
                    dly_val  = cfg_post[cur_cs_q];
                end
            end
            ST_HOLD: begin
                if (dly_zero) begin
                    if (req_valid && (req_cs == cur_cs_q)) begin
                        cap_cs  = 1'b1;
                        sh_load = 1'b1;
                        state_d = ST_SHIFT;
                    end else begin
                        cs_clr   = 1'b1;
                        gap_load = 1'b1;
                        state_d  = ST_IDLE;
                        if (req_valid) begin
                            if (cfg_div[req_cs] == '0) begin
                                err_set = 1'b1;
                            end else begin
                                cap_cs  = 1'b1;
                                sh_load = 1'b1;
                                state_d = ST_GAP;
                            end
                        end
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs and select bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q      <= '1;
            err_q       <= 1'b0;
            cur_cs_q    <= '0;
            last_cs_q   <= '0;
            have_last_q <= 1'b0;
        end else begin
            err_q <= err_set;
            if (cap_cs) begin
                cur_cs_q <= req_cs;
            end
            if (cs_set) begin
                cs_n_q      <= ~(NUM_CS'(1) << sel_cs);
                last_cs_q   <= sel_cs;
                have_last_q <= 1'b1;
            end else if (cs_clr) begin
                cs_n_q <= '1;
            end
        end
    end

    assign cs_n      = cs_n_q;
    assign cfg_err   = err_q;
    assign rsp_valid = sh_done;
    assign rsp_data  = sh_rx;

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n_q) <= 1); // R2

    AST_SCLK_ONLY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (state_q == ST_SHIFT)); // R9

    AST_SCLK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (cs_n_q != '1)); // R2

    AST_ZERO_DIV_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cfg_div[req_cs] == '0) |=> cfg_err); // R4

    AST_ERR_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (cs_n_q == '1)); // R4

    AST_READY_NOT_CLOCKING: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !req_ready); // R11

endmodule

// File: tb/tb_spi_sel_master.sv
`timescale 1ns/1ps
module tb_spi_sel_master;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0][7:0] cfg_div;
    logic [3:0][7:0] cfg_pre;
    logic [3:0][7:0] cfg_post;
    logic [7:0]      cfg_gap;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [1:0]      req_cs = 2'd0;
    logic [7:0]      req_data = 8'd0;
    logic            rsp_valid;
    logic [7:0]      rsp_data;
    logic            cfg_err;
    logic            sclk;
    logic            mosi;
    logic            miso;
    logic [3:0]      cs_n;

    always #2 clk = ~clk;

    spi_sel_master dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_div   (cfg_div),
        .cfg_pre   (cfg_pre),
        .cfg_post  (cfg_post),
        .cfg_gap   (cfg_gap),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_cs    (req_cs),
        .req_data  (req_data),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .cfg_err   (cfg_err),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso),
        .cs_n      (cs_n)
    );

    localparam int DIVS [4] = '{1, 3, 2, 5};
    localparam int PRES [4] = '{0, 2, 1, 4};
    localparam int POSTS[4] = '{1, 0, 3, 2};
    localparam int GAP      = 3;

    typedef struct packed {
        logic [1:0] cs;
        logic [7:0] tx;
        logic [7:0] slv;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 8'hA5, 8'h3C},
        '{2'd1, 8'h81, 8'h7E},
        '{2'd2, 8'h0F, 8'hC1},
        '{2'd3, 8'hF0, 8'h12},
        '{2'd1, 8'h5A, 8'h80},
        '{2'd0, 8'h01, 8'hFE}
    };

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Slave model and port monitor
    logic [7:0] slv_byte = 8'h00;
    logic [2:0] rcnt = 3'd0;
    assign miso = slv_byte[3'd7 - rcnt];

    int cyc = 0;
    int t_cs_fall = 0, t_cs_rise = 0, hi_len = 0;
    int t_first_rise = 0, t_rise = 0, t_last_rise = 0, t_last_fall = 0;
    int from_prev_fall = 0, hi_w = 0, t_rsp = 0;
    int cs_fall_cnt = 0, cs_rise_cnt = 0, rsp_cnt = 0, err_cnt = 0;
    int multi_low = 0, bad_ready = 0, mosi_move_hi = 0;
    logic [7:0] cap = 8'd0, cap_done = 8'd0, got = 8'd0;
    logic [3:0] prev_cs = 4'hF;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if ($countones(~cs_n) > 1) multi_low = multi_low + 1;
        if (sclk && req_ready) bad_ready = bad_ready + 1;
        if (sclk && prev_sclk && (mosi != prev_mosi)) mosi_move_hi = mosi_move_hi + 1;
        if (prev_cs == 4'hF && cs_n != 4'hF) begin
            t_cs_fall = cyc; hi_len = cyc - t_cs_rise; cs_fall_cnt = cs_fall_cnt + 1;
        end
        if (prev_cs != 4'hF && cs_n == 4'hF) begin
            t_cs_rise = cyc; cs_rise_cnt = cs_rise_cnt + 1;
        end
        if (!prev_sclk && sclk) begin
            if (rcnt == 3'd0) begin
                t_first_rise = cyc; from_prev_fall = cyc - t_last_fall;
            end
            cap = {cap[6:0], mosi};
            t_rise = cyc;
            if (rcnt == 3'd7) begin
                t_last_rise = cyc; cap_done = cap;
            end
            rcnt = rcnt + 3'd1;
        end
        if (prev_sclk && !sclk) begin
            t_last_fall = cyc; hi_w = cyc - t_rise;
        end
        if (rsp_valid) begin
            t_rsp = cyc; rsp_cnt = rsp_cnt + 1; got = rsp_data;
        end
        if (cfg_err) err_cnt = err_cnt + 1;
        prev_cs = cs_n; prev_sclk = sclk; prev_mosi = mosi;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] c, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_cs = c; req_data = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_release(input int n_rise);
        while (cs_rise_cnt < n_rise) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks = checks + 1;
        fails  = fails + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            cfg_div[i]  = 8'(DIVS[i]);
            cfg_pre[i]  = 8'(PRES[i]);
            cfg_post[i] = 8'(POSTS[i]);
        end
        cfg_gap = 8'(GAP);
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 cs_n", int'(cs_n), 15);
        chk("R1 sclk", int'(sclk), 0);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 cfg_err", int'(cfg_err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 cs_n after release", int'(cs_n), 15);

        // Table of frames
        for (int i = 0; i < 6; i++) begin
            automatic int c = int'(VECS[i].cs);
            automatic int r0 = cs_rise_cnt;
            automatic bit diff = (i > 0) && (VECS[i].cs != VECS[i-1].cs);
            slv_byte = VECS[i].slv;
            send(VECS[i].cs, VECS[i].tx);
            wait_release(r0 + 1);
            chk("R10 rx byte", int'(got), int'(VECS[i].slv));
            chk("R9 mosi byte", int'(cap_done), int'(VECS[i].tx));
            chk("R5 setup span", t_first_rise - t_cs_fall, PRES[c] + 1 + DIVS[c]);
            chk("R3 high half", hi_w, DIVS[c]);
            chk("R6 hold span", t_cs_rise - t_last_fall, POSTS[c] + 1);
            chk("R10 pulse edge", t_rsp, t_last_rise);
            if (diff) chk("R8 gap min", int'(hi_len >= GAP + 1), 1);
            repeat (2) @(negedge clk);
        end

        // R7: two queued frames on the same select
        begin
            automatic int f0 = cs_fall_cnt;
            automatic int r0 = cs_rise_cnt;
            automatic int n0 = rsp_cnt;
            slv_byte = 8'h96;
            send(2'd1, 8'h33);
            send(2'd1, 8'hCC);
            wait_release(r0 + 1);
            chk("R7 one assert", cs_fall_cnt - f0, 1);
            chk("R7 two frames", rsp_cnt - n0, 2);
            chk("R7 back-to-back span", from_prev_fall, POSTS[1] + 1 + DIVS[1]);
            chk("R7 second tx", int'(cap_done), 8'hCC);
            chk("R7 second rx", int'(got), 8'h96);
        end
        repeat (2) @(negedge clk);

        // R8: queued frame to a different select gets the exact gap
        begin
            automatic int r0 = cs_rise_cnt;
            slv_byte = 8'h4B;
            send(2'd0, 8'h11);
            send(2'd2, 8'h22);
            wait_release(r0 + 2);
            chk("R8 exact gap", hi_len, GAP + 1);
            chk("R8 second tx", int'(cap_done), 8'h22);
            chk("R2 single low", multi_low, 0);
        end
        repeat (2) @(negedge clk);

        // R4: zero divisor refused
        begin
            automatic int f0 = cs_fall_cnt;
            automatic int e0 = err_cnt;
            cfg_div[3] = 8'd0;
            send(2'd3, 8'h77);
            repeat (6) @(negedge clk);
            chk("R4 error pulse", err_cnt - e0, 1);
            chk("R4 no select", cs_fall_cnt - f0, 0);
            chk("R4 cs_n high", int'(cs_n), 15);
            chk("R4 ready again", int'(req_ready), 1);
            cfg_div[3] = 8'(DIVS[3]);
        end

        // R3: slowest divisor
        begin
            automatic int r0 = cs_rise_cnt;
            cfg_div[3] = 8'd255;
            slv_byte = 8'hE7;
            send(2'd3, 8'h69);
            wait_release(r0 + 1);
            chk("R3 high half 255", hi_w, 255);
            chk("R5 setup span 255", t_first_rise - t_cs_fall, PRES[3] + 1 + 255);
            chk("R10 rx 255", int'(got), 8'hE7);
            cfg_div[3] = 8'(DIVS[3]);
        end

        chk("R11 ready low while clocking", bad_ready, 0);
        chk("R9 mosi still in high phase", mosi_move_hi, 0);
        chk("R2 single low end", multi_low, 0);
        finish_run();
    end

endmodule